// File: doc/BRIEF.md
# Four-Port Memory Self-Test Sequencer

This block drives the built-in self-test of a shared memory with four access ports. Each port has an 18-bit data lane, and all ports share one 16-bit address. After a start pulse the sequencer runs four data-pattern algorithms in a fixed order: moving inversion, a two-pattern march, a checkerboard, and a unique-address pattern. In every read step it compares the word returned on all four ports against the expected value. Write duty depends on the algorithm. The first port writes the moving inversion, march and checkerboard data. The unique-address data is written by the port that address bits [1:0] select.

The sequencer has two modes, chosen at start time. In normal mode a full pass produces a sticky pass/fail result and a done flag. In debug mode each run captures the first failure that has not been reported yet. The capture holds the per-bit mismatch vector of all four lanes, the failing address and the controller state code. The run then keeps going and looks for any further unreported failure. If it finds one, it halts with done low to signal that another run is needed. If it finds none, it finishes with done high. A failure count kept across debug runs lets each new run skip failures it has already reported.

The memory is outside the block. Read data must come back combinationally in the same cycle as the address.

Top module: `mp_bist_top`

## Requirements
- R1: A full run issues 19×DEPTH operation cycles, counted from the clock edge that accepts start to the edge that sets done. The elements run in this order: write 0 ascending; read 0/write 1 ascending; read 1/write 0 descending; read 0 descending; write 2AAAA ascending; read 2AAAA/write 15555 ascending; read 15555/write 2AAAA descending; read 2AAAA ascending; write checker ascending; read checker ascending; write inverted checker ascending; read inverted checker ascending; write unique ascending; read unique ascending; read unique descending. The checker word is 2AAAA at odd addresses and 15555 at even addresses. A start pulse while a run is active is ignored.
- R2: Lane 0 (port 1) is the only writer in the first twelve elements. In the unique-address write element, each address is written by exactly one lane, namely lane addr[1:0]. Lanes 1 to 3 write at no other time.
- R3: The unique-address word for address a is {a[1:0], a[15:0]}. After a clean run every memory word holds that value.
- R4: Every read cycle compares all four lanes. Bit b of lane p maps to mismatch bit p*18+b, where 1 means mismatch.
- R5: pass starts at 1 after reset and drops to 0 on any mismatch. It stays 0 until reset, across later runs.
- R6: Once done is set, the state code and pass do not change on further clocks until the next start.
- R7: mode is sampled only on the accepted start. The value 2'b01 selects debug, and any other value selects normal mode. The stored mode resets to 2'b00.
- R8: ctrl_state is 0 when idle, 1+2×element+phase while running (phase 0 = read, 1 = write), 31 when halted and 32 when done.
- R9: In debug, a run captures the first unreported failing read and sets snap_valid, with the address, the mismatch vector and the read-phase state code. It halts (ctrl_state 31, done 0) on the next unreported failure, or otherwise finishes with done 1. In normal mode snap_valid stays 0.
- R10: The reported-failure count persists across debug starts. Reset or a normal-mode start clears it.
- R11: After reset: busy 0, done 0, pass 1, ctrl_state 0, no write enables, snap_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted when no run is active |
| mode | input | 2 | Run mode, 2'b01 = debug |
| mem_addr | output | 16 | Address shared by all ports |
| mem_we | output | 4 | Write enable per port |
| mem_wdata | output | 72 | Write data, lane p at [p*18 +: 18] |
| mem_rdata | input | 72 | Read data per port, same-cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Sticky pass result |
| ctrl_state | output | 6 | Controller state code |
| snap_valid | output | 1 | Debug failure snapshot valid |
| fail_vec | output | 72 | Captured per-bit mismatch vector |
| fail_addr | output | 16 | Captured failing address |
| fail_state | output | 6 | State code at the captured failure |

## Verification
The assertions take three things for granted. The memory answers a read in the same cycle as the address. At most one port writes in any cycle. start is a short pulse. The bench memory therefore decodes reads combinationally and commits writes on the clock edge. Stuck-at faults are injected only on the read path, either in a single cell shared by all ports or in one lane of one port, so every expected failure list can be derived by hand from the element order. Inputs change only on the falling edge, and start is never held across a whole run.

// File: rtl/mbist_pkg.sv
// Shared types for the four-port memory self-test sequencer.
// Holds the element table (the algorithm program) and the data-pattern function.
package mbist_pkg;
    localparam int NPORT = 4;
    localparam int DW    = 18;
    localparam int AW    = 16;
    localparam int SW    = 6;
    localparam int EW    = 4;
    localparam int NELEM = 15;

    localparam logic [SW-1:0] CODE_IDLE = 6'd0;
    localparam logic [SW-1:0] CODE_HALT = 6'd31;
    localparam logic [SW-1:0] CODE_DONE = 6'd32;

    localparam logic [DW-1:0] WORD_ALT  = 18'h2AAAA;
    localparam logic [DW-1:0] WORD_ALTN = 18'h15555;

    typedef enum logic [2:0] {
        PAT_ZERO, PAT_ONES, PAT_ALT, PAT_ALTN, PAT_CHK, PAT_CHKN, PAT_UADR
    } pat_e;

    typedef struct packed {
        logic down;
        logic rd;
        pat_e rpat;
        logic wr;
        pat_e wpat;
    } elem_t;

    function automatic elem_t mk(logic dn, logic r, pat_e rp, logic w, pat_e wp);
        elem_t e;
        e.down = dn; e.rd = r; e.rpat = rp; e.wr = w; e.wpat = wp;
        return e;
    endfunction

    // Element program: moving inversion, march, checkerboard, unique address.
    function automatic elem_t elem_lookup(logic [EW-1:0] i);
        case (i)
            4'd0:    return mk(1'b0, 1'b0, PAT_ZERO, 1'b1, PAT_ZERO);
            4'd1:    return mk(1'b0, 1'b1, PAT_ZERO, 1'b1, PAT_ONES);
            4'd2:    return mk(1'b1, 1'b1, PAT_ONES, 1'b1, PAT_ZERO);
            4'd3:    return mk(1'b1, 1'b1, PAT_ZERO, 1'b0, PAT_ZERO);
            4'd4:    return mk(1'b0, 1'b0, PAT_ZERO, 1'b1, PAT_ALT);
            4'd5:    return mk(1'b0, 1'b1, PAT_ALT,  1'b1, PAT_ALTN);
            4'd6:    return mk(1'b1, 1'b1, PAT_ALTN, 1'b1, PAT_ALT);
            4'd7:    return mk(1'b0, 1'b1, PAT_ALT,  1'b0, PAT_ZERO);
            4'd8:    return mk(1'b0, 1'b0, PAT_ZERO, 1'b1, PAT_CHK);
            4'd9:    return mk(1'b0, 1'b1, PAT_CHK,  1'b0, PAT_ZERO);
            4'd10:   return mk(1'b0, 1'b0, PAT_ZERO, 1'b1, PAT_CHKN);
            4'd11:   return mk(1'b0, 1'b1, PAT_CHKN, 1'b0, PAT_ZERO);
            4'd12:   return mk(1'b0, 1'b0, PAT_ZERO, 1'b1, PAT_UADR);
            4'd13:   return mk(1'b0, 1'b1, PAT_UADR, 1'b0, PAT_ZERO);
            4'd14:   return mk(1'b1, 1'b1, PAT_UADR, 1'b0, PAT_ZERO);
            default: return mk(1'b0, 1'b0, PAT_ZERO, 1'b0, PAT_ZERO);
        endcase
    endfunction

    // Data word of a pattern at a given address.
    function automatic logic [DW-1:0] pat_word(pat_e p, logic [AW-1:0] a);
        case (p)
            PAT_ZERO: return '0;
            PAT_ONES: return '1;
            PAT_ALT:  return WORD_ALT;
            PAT_ALTN: return WORD_ALTN;
            PAT_CHK:  return a[0] ? WORD_ALT  : WORD_ALTN;
            PAT_CHKN: return a[0] ? WORD_ALTN : WORD_ALT;
            default:  return {a[1:0], a};
        endcase
    endfunction
endpackage

// File: rtl/mbist_addr_gen.sv
// Address sweeper: loads the first address of an element, then steps up or down.
// Assumes DEPTH fits in the address width and is at least 4.
module mbist_addr_gen #(
    parameter int AW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          init_down,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    // Address register: load on element entry, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (init)   addr <= init_down ? TOP : '0;
        else if (step)   addr <= down ? addr - 1'b1 : addr + 1'b1;
    end

    // Last address of the sweep in the current direction.
    always_comb at_end = down ? (addr == '0) : (addr == TOP);

    assert_addr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= TOP);
endmodule

// File: rtl/mbist_pattern.sv
// Pattern decode: expected read word and per-port write enables and data
// for the current element and address. Lane 0 owns all writes except the
// unique-address element, where lane addr[1:0] writes.
module mbist_pattern
    import mbist_pkg::*;
#(
    parameter int EWI = EW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EWI-1:0]      elem,
    input  logic                wr_phase,
    input  logic                active,
    input  logic [AW-1:0]       addr,
    output logic [DW-1:0]       expect_word,
    output logic [NPORT-1:0]    we,
    output logic [NPORT*DW-1:0] wdata
);
    pat_e rp, wp;
    logic wr_ok;

    // Decode the element fields needed here.
    always_comb begin
        rp    = elem_lookup(elem).rpat;
        wp    = elem_lookup(elem).wpat;
        wr_ok = active && wr_phase && elem_lookup(elem).wr;
        expect_word = pat_word(rp, addr);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        // Write enable and data of lane p.
        always_comb begin
            wdata[p*DW +: DW] = pat_word(wp, addr);
            if (wp == PAT_UADR) we[p] = wr_ok && (addr[1:0] == 2'(p));
            else                we[p] = wr_ok && (p == 0);
        end
    end

    assert_single_writer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
endmodule

// File: rtl/mbist_compare.sv
// Lane comparator: XOR of every port's read word with the expected word.
// Assumes read data is valid in the cycle the address is presented.
module mbist_compare
    import mbist_pkg::*;
(
    input  logic                en,
    input  logic [DW-1:0]       expect_word,
    input  logic [NPORT*DW-1:0] rdata,
    output logic [NPORT*DW-1:0] mvec,
    output logic                any_fail
);
    for (genvar p = 0; p < NPORT; p++) begin : g_cmp
        // Per-bit mismatch of lane p, gated by the read strobe.
        always_comb mvec[p*DW +: DW] = en ? (rdata[p*DW +: DW] ^ expect_word) : '0;
    end

    // Any bit on any lane differs.
    always_comb any_fail = |mvec;
endmodule

// File: rtl/mbist_ctrl.sv
// Sequencer FSM: walks the element program, handles pass/fail and the
// debug replay (skip reported failures, capture one, halt on the next).
// Assumes start is a pulse and the compare result is valid in read cycles.
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int FCW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode,
    input  logic                any_fail,
    input  logic [NPORT*DW-1:0] mvec,
    input  logic [AW-1:0]       addr,
    input  logic                at_end,
    output logic [EW-1:0]       elem,
    output logic                wr_phase,
    output logic                active,
    output logic                rd_strobe,
    output logic                init,
    output logic                init_down,
    output logic                step,
    output logic                down,
    output logic [SW-1:0]       state_code,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic                snap_valid,
    output logic [NPORT*DW-1:0] fail_vec,
    output logic [AW-1:0]       fail_addr,
    output logic [SW-1:0]       fail_state
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_HALT, S_DONE} st_e;

    localparam logic [EW-1:0] LAST = EW'(NELEM - 1);

    st_e            st;
    logic [1:0]     mode_q;
    logic [FCW-1:0] seen_q, rep_q;
    logic           cap_q, pass_q;
    logic           start_ok, dbg, cur_rd, cur_wr, nxt_rd, halt_now, go_wr, advance, last;
    logic [EW-1:0]  elem_nx;

    // Step decisions for the current cycle.
    always_comb begin
        elem_nx   = elem + 1'b1;
        cur_rd    = elem_lookup(elem).rd;
        cur_wr    = elem_lookup(elem).wr;
        nxt_rd    = elem_lookup(elem_nx).rd;
        down      = elem_lookup(elem).down;
        dbg       = (mode_q == 2'b01);
        start_ok  = start && (st != S_RUN);
        active    = (st == S_RUN);
        rd_strobe = active && !wr_phase;
        halt_now  = rd_strobe && any_fail && dbg && cap_q;
        go_wr     = rd_strobe && cur_wr && !halt_now;
        advance   = active && !halt_now && (wr_phase || !cur_wr);
        last      = at_end && (elem == LAST);
        step      = advance && !at_end;
        init      = start_ok || (advance && at_end && !last);
        init_down = start_ok ? elem_lookup('0).down : elem_lookup(elem_nx).down;
    end

    // Main sequencer, result and debug-replay registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; elem <= '0; wr_phase <= 1'b0; mode_q <= 2'b00;
            seen_q <= '0; rep_q <= '0; cap_q <= 1'b0; pass_q <= 1'b1;
            fail_vec <= '0; fail_addr <= '0; fail_state <= '0;
        end else if (start_ok) begin
            st <= S_RUN; elem <= '0; wr_phase <= !elem_lookup('0).rd;
            mode_q <= mode; seen_q <= '0; cap_q <= 1'b0;
            if (mode != 2'b01) rep_q <= '0;
        end else if (active) begin
            if (rd_strobe && any_fail) pass_q <= 1'b0;
            if (halt_now) begin
                st <= S_HALT;
            end else begin
                if (rd_strobe && any_fail && dbg && !cap_q) begin
                    if (seen_q == rep_q) begin
                        cap_q      <= 1'b1;
                        rep_q      <= rep_q + 1'b1;
                        fail_vec   <= mvec;
                        fail_addr  <= addr;
                        fail_state <= SW'(1 + 2 * int'(elem));
                    end else begin
                        seen_q <= seen_q + 1'b1;
                    end
                end
                if (go_wr) begin
                    wr_phase <= 1'b1;
                end else if (advance) begin
                    if (last) begin
                        st <= S_DONE;
                    end else if (at_end) begin
                        elem <= elem_nx; wr_phase <= !nxt_rd;
                    end else begin
                        wr_phase <= !cur_rd;
                    end
                end
            end
        end
    end

    // Status decode.
    always_comb begin
        busy       = active;
        done       = (st == S_DONE);
        pass       = pass_q;
        snap_valid = cap_q && dbg;
        case (st)
            S_IDLE:  state_code = CODE_IDLE;
            S_HALT:  state_code = CODE_HALT;
            S_DONE:  state_code = CODE_DONE;
            default: state_code = SW'(1 + 2 * int'(elem) + int'(wr_phase));
        endcase
    end

    assert_done_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE && !start) |=> (st == S_DONE && $stable(pass_q)));
    assert_pass_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_q |=> !pass_q);
    assert_halt_has_snap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALT) |-> cap_q);
    assert_count_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN) |=> (rep_q >= $past(rep_q)));
endmodule

// File: rtl/mp_bist_top.sv
// Top of the four-port memory self-test sequencer. Connects the FSM,
// address sweeper, pattern decode and lane comparator.
// Assumes the memory returns read data in the same cycle as mem_addr.
module mp_bist_top
    import mbist_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int FCW   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode,
    output logic [AW-1:0]       mem_addr,
    output logic [NPORT-1:0]    mem_we,
    output logic [NPORT*DW-1:0] mem_wdata,
    input  logic [NPORT*DW-1:0] mem_rdata,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic [SW-1:0]       ctrl_state,
    output logic                snap_valid,
    output logic [NPORT*DW-1:0] fail_vec,
    output logic [AW-1:0]       fail_addr,
    output logic [SW-1:0]       fail_state
);
    logic [EW-1:0]       elem;
    logic                wr_phase, active, rd_strobe, init, init_down, step, down, at_end, any_fail;
    logic [DW-1:0]       expect_word;
    logic [NPORT*DW-1:0] mvec;

    mbist_ctrl #(.FCW(FCW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .any_fail(any_fail), .mvec(mvec), .addr(mem_addr), .at_end(at_end),
        .elem(elem), .wr_phase(wr_phase), .active(active), .rd_strobe(rd_strobe),
        .init(init), .init_down(init_down), .step(step), .down(down),
        .state_code(ctrl_state), .busy(busy), .done(done), .pass(pass),
        .snap_valid(snap_valid), .fail_vec(fail_vec), .fail_addr(fail_addr),
        .fail_state(fail_state)
    );

    mbist_addr_gen #(.AW(AW), .DEPTH(DEPTH)) u_addr (
        .clk(clk), .rst_n(rst_n), .init(init), .init_down(init_down),
        .step(step), .down(down), .addr(mem_addr), .at_end(at_end)
    );

    mbist_pattern u_pat (
        .clk(clk), .rst_n(rst_n), .elem(elem), .wr_phase(wr_phase), .active(active),
        .addr(mem_addr), .expect_word(expect_word), .we(mem_we), .wdata(mem_wdata)
    );

    mbist_compare u_cmp (
        .en(rd_strobe), .expect_word(expect_word), .rdata(mem_rdata),
        .mvec(mvec), .any_fail(any_fail)
    );

    // Ports 2..4 write only in the unique-address write element (code 26).
    assert_side_ports_ua_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we[NPORT-1:1]) |-> (ctrl_state == 6'd26));
    assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_we == '0));
endmodule

// File: tb/sim_mp_bist_top.sv
// Directed bench: behavioural four-port memory with read-path stuck-at faults.
module sim_mp_bist_top;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] mem_addr;
    logic [3:0]  mem_we;
    logic [71:0] mem_wdata, mem_rdata;
    logic        busy, done, pass, snap_valid;
    logic [5:0]  ctrl_state, fail_state;
    logic [71:0] fail_vec;
    logic [15:0] fail_addr;

    int tests = 0, fails = 0, cycles = 0;
    int wr_cnt [4];
    logic [17:0] mem [D];

    // Fault controls: cell fault (all ports) and lane fault (one port).
    logic        cf_en = 0; int cf_addr = 0; int cf_bit = 0; logic cf_val = 0;
    logic        pf_en = 0; int pf_lane = 0; int pf_bit = 0; logic pf_val = 0;

    mp_bist_top #(.DEPTH(D), .FCW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass), .ctrl_state(ctrl_state),
        .snap_valid(snap_valid), .fail_vec(fail_vec), .fail_addr(fail_addr),
        .fail_state(fail_state)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        for (int p = 0; p < 4; p++) begin
            if (mem_we[p]) begin
                mem[int'(mem_addr) % D] <= mem_wdata[p*18 +: 18];
                wr_cnt[p] <= wr_cnt[p] + 1;
            end
        end
    end

    always_comb begin
        for (int p = 0; p < 4; p++) begin
            logic [17:0] w;
            w = mem[int'(mem_addr) % D];
            if (cf_en && int'(mem_addr) == cf_addr) w[cf_bit] = cf_val;
            if (pf_en && p == pf_lane) w[pf_bit] = pf_val;
            mem_rdata[p*18 +: 18] = w;
        end
    end

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0; start = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Start a run; return edges from accept to done/halt. Optional mid-run pokes.
    task automatic do_run(input logic [1:0] m, input logic poke, output int cyc);
        @(negedge clk); mode = m; start = 1;
        @(negedge clk); start = 0; cyc = 0;
        while (!(done || ctrl_state == 6'd31) && cyc < 2000) begin
            @(negedge clk); cyc++;
            if (poke && cyc == 100) begin mode = ~m; start = 1; end
            if (poke && cyc == 101) start = 0;
        end
        mode = m;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 busy", busy, 0); chk("R11 done", done, 0); chk("R11 pass", pass, 1);
        chk("R11 state", ctrl_state, 0); chk("R11 we", mem_we, 0); chk("R11 snap", snap_valid, 0);
    endtask

    task automatic t_clean();
        int c, bad;
        for (int p = 0; p < 4; p++) wr_cnt[p] = 0;
        do_run(2'b00, 1'b1, c);
        chk("R1 cycles", c, 19 * D);
        chk("R5 done", done, 1); chk("R5 pass", pass, 1);
        chk("R8 done code", ctrl_state, 32); chk("R9 no snap normal", snap_valid, 0);
        chk("R2 lane0 writes", wr_cnt[0], 8 * D + D / 4);
        chk("R2 lane1 writes", wr_cnt[1], D / 4);
        chk("R2 lane3 writes", wr_cnt[3], D / 4);
        bad = 0;
        for (int a = 0; a < D; a++) begin
            logic [15:0] av;
            av = 16'(a);
            if (mem[a] !== {av[1:0], av}) bad++;
        end
        chk("R3 unique contents", bad, 0);
    endtask

    task automatic t_frozen();
        repeat (40) @(negedge clk);
        chk("R6 state", ctrl_state, 32); chk("R6 done", done, 1); chk("R6 pass", pass, 1);
    endtask

    task automatic t_normal_fault();
        int c;
        cf_en = 1; cf_addr = 5; cf_bit = 0; cf_val = 1;
        do_run(2'b11, 1'b1, c);
        chk("R7 mode 11 runs full", c, 19 * D);
        chk("R5 fail", pass, 0); chk("R7 no snap", snap_valid, 0);
        cf_en = 0;
        do_run(2'b00, 1'b0, c);
        chk("R5 sticky after clean rerun", pass, 0);
        chk("R5 done", done, 1);
    endtask

    task automatic t_debug_cell();
        int c;
        logic [71:0] m;
        int codes [5] = '{3, 7, 11, 15, 19};
        m = '0;
        for (int p = 0; p < 4; p++) m[p*18] = 1'b1;
        do_reset();
        cf_en = 1; cf_addr = 5; cf_bit = 0; cf_val = 1;
        for (int r = 0; r < 5; r++) begin
            do_run(2'b01, 1'b0, c);
            chk("R9 snap valid", snap_valid, 1);
            chk("R4 lane vector", fail_vec, m);
            chk("R9 fail addr", fail_addr, 5);
            chk("R9 fail state", fail_state, codes[r]);
            chk("R9 done flag", done, (r == 4) ? 1 : 0);
            chk("R8 end code", ctrl_state, (r == 4) ? 32 : 31);
        end
        do_run(2'b01, 1'b0, c);
        chk("R10 all reported", snap_valid, 0);
        chk("R10 done", done, 1);
        do_run(2'b00, 1'b0, c);
        do_run(2'b01, 1'b0, c);
        chk("R10 cleared by normal start", fail_state, 3);
        chk("R10 halted again", ctrl_state, 31);
        cf_en = 0;
    endtask

    task automatic t_debug_lane();
        int c;
        logic [71:0] m;
        m = '0; m[2*18 + 17] = 1'b1;
        do_reset();
        pf_en = 1; pf_lane = 2; pf_bit = 17; pf_val = 0;
        do_run(2'b01, 1'b0, c);
        chk("R4 lane2 bit17", fail_vec, m);
        chk("R1 descending start addr", fail_addr, 15);
        chk("R8 read code elem2", fail_state, 5);
        chk("R9 halt", done, 0);
        pf_en = 0;
    endtask

    initial begin
        for (int a = 0; a < D; a++) mem[a] = '0;
        for (int p = 0; p < 4; p++) wr_cnt[p] = 0;
        t_reset();
        t_clean();
        t_frozen();
        t_normal_fault();
        t_debug_cell();
        t_debug_lane();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule